// File: doc/BRIEF.md
# MDIO Clause 45 Slave Frame Engine

This block is a management-interface slave for a PHY-side device. It watches the MDC clock and the MDIO data line, finds a preamble, and decodes Clause 45 frames of four kinds: address, write, read and post-read-increment-address. The block checks the port-address and device-address fields of each frame against expected values. When a read-type frame matches, it drives a transmit word back onto MDIO.

Each expected port-address bit comes either from an input pin or from a software bit, and a per-bit select chooses between them. A small word-wide register bus gives access to four registers:

| Offset | Register | Access |
|--------|----------|--------|
| 0 | Last received address word | Read-only |
| 1 | Transmit data word | Read-write |
| 2 | Expected-address configuration | Read-write |
| 3 | Sticky progress flags | Cleared by a read |

MDC and MDIO are brought into the system clock domain through two-flop synchronizers. A bit is taken on each detected rising edge of MDC.

Top module: `mdio_c45_slave`

## Requirements
- R1: After reset, register 0 reads 0x0000, register 1 reads 0x0000, register 2 reads 0x0400 (expected device address 1), register 3 reads 0x0000, and `mdio_oe` is 0.
- R2: Bus writes to offset 1 and offset 2 are read back unchanged, with one exception: bit 15 of offset 2 always reads 0. Bus writes to offset 0 and offset 3 have no effect.
- R3: In the configuration word, bits [4:0] are software port bits, bits [9:5] are selects and bits [14:10] are the expected device address. Expected port bit i equals `prt_pins[i]` when select bit i is 0, and software bit i when select bit i is 1.
- R4: A frame is recognised only after at least PRE_MIN consecutive ones followed by the start bits 00. With fewer ones, the frame sets no flag and captures nothing.
- R5: At the end of the port-address field, status bit 6 is set if the field equals the expected port address; otherwise status bit 7 is set.
- R6: At the end of the device-address field, status bit 4 is set if the field equals the expected device address; otherwise status bit 5 is set.
- R7: At the end of the data field, a frame-type flag is set only when both addresses matched. The flags are bit 1 for opcode 00 (address), bit 0 for opcode 01 (write), bit 3 for opcode 11 (read) and bit 2 for opcode 10 (post-read-increment).
- R8: Status flags are sticky: flags set by successive frames accumulate. A bus read of offset 3 returns the flags and clears them.
- R9: The 16-bit data field of a matching address frame is captured into register 0. The data field of any other frame leaves register 0 unchanged.
- R10: In a matching read or post-read-increment frame, the slave behaves as follows:
  - It leaves MDIO released during the first turnaround bit.
  - It drives 0 in the second turnaround bit.
  - It drives register 1 MSB first over the 16 data bits.
  - It releases MDIO after the last data bit.
- R11: A frame whose port or device address does not match never enables the MDIO driver. After that frame ends, the next frame is decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| prt_pins | input | 5 | Strapped port-address pins |
| bus_sel | input | 1 | Register access strobe, one clock per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the offset |

## Verification
The bench builds the block with PRE_MIN = 16. This halves the preamble length of every frame, so the whole set of frames stays short. It also puts the exact boundary within easy reach: a frame with 15 ones must be ignored, and a frame with 16 ones must be decoded. MDC runs at one eighth of the system clock. That spacing leaves room for the two synchronizer stages plus the output register before the station samples the driven bit at the end of the low phase.

// File: rtl/mdio_c45_slave.sv
module mdio_c45_slave #(
  parameter int PRE_MIN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic [4:0]  prt_pins,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata
);
  localparam int PW = $clog2(PRE_MIN + 1);
  localparam logic [PW-1:0] PRE_TOP = PW'(PRE_MIN);

  typedef enum logic [2:0] {HUNT, START, OPC, PRT, DEV, TA, DATA} st_t;

  st_t         state;
  logic [PW-1:0] pre_cnt;
  logic [3:0]  bcnt;
  logic [2:0]  mdc_sy;
  logic [1:0]  dio_sy;
  logic [1:0]  op;
  logic [15:0] sh, txsh, rx_adr, tx_dat, cfg;
  logic [7:0]  flags, set;
  logic        prt_ok, dev_ok;

  wire       rise    = mdc_sy[1] & ~mdc_sy[2];
  wire       bit_in  = dio_sy[1];
  wire [4:0] got5    = {sh[3:0], bit_in};
  wire [4:0] exp_prt = (cfg[9:5] & cfg[4:0]) | (~cfg[9:5] & prt_pins);
  wire       end_prt = rise && state == PRT && bcnt == 4'd4;
  wire       end_dev = rise && state == DEV && bcnt == 4'd4;
  wire       end_frm = rise && state == DATA && bcnt == 4'd15;
  wire       both    = prt_ok & dev_ok;
  wire       rd_go   = op[1] & both;
  wire       rd_sts  = bus_sel && !bus_wr && bus_addr == 2'd3;

  always_comb begin
    set    = '0;
    set[7] = end_prt && got5 != exp_prt;
    set[6] = end_prt && got5 == exp_prt;
    set[5] = end_dev && got5 != cfg[14:10];
    set[4] = end_dev && got5 == cfg[14:10];
    set[3] = end_frm && both && op == 2'b11;
    set[2] = end_frm && both && op == 2'b10;
    set[1] = end_frm && both && op == 2'b00;
    set[0] = end_frm && both && op == 2'b01;
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = rx_adr;
      2'd1:    bus_rdata = tx_dat;
      2'd2:    bus_rdata = cfg;
      default: bus_rdata = {8'h00, flags};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HUNT; pre_cnt <= '0; bcnt <= '0;
      mdc_sy <= '0; dio_sy <= '0; op <= '0;
      sh <= '0; txsh <= '0; rx_adr <= '0; tx_dat <= '0;
      cfg <= 16'h0400; flags <= '0;
      prt_ok <= 1'b0; dev_ok <= 1'b0;
      mdio_o <= 1'b0; mdio_oe <= 1'b0;
    end else begin
      mdc_sy <= {mdc_sy[1:0], mdc};
      dio_sy <= {dio_sy[0], mdio_i};
      flags  <= (flags & ~{8{rd_sts}}) | set;
      if (bus_sel && bus_wr) begin
        if (bus_addr == 2'd1) tx_dat <= bus_wdata;
        if (bus_addr == 2'd2) cfg    <= bus_wdata & 16'h7FFF;
      end
      if (rise) begin
        sh   <= {sh[14:0], bit_in};
        bcnt <= bcnt + 4'd1;
        case (state)
          HUNT: begin
            bcnt <= '0;
            if (bit_in) begin
              if (pre_cnt != PRE_TOP) pre_cnt <= pre_cnt + 1'b1;
            end else begin
              if (pre_cnt == PRE_TOP) state <= START;
              pre_cnt <= '0;
            end
          end
          START: begin
            bcnt <= '0;
            if (bit_in) begin
              state <= HUNT; pre_cnt <= PW'(1);
            end else state <= OPC;
          end
          OPC: begin
            op <= {op[0], bit_in};
            if (bcnt == 4'd1) begin bcnt <= '0; state <= PRT; end
          end
          PRT: if (bcnt == 4'd4) begin
            bcnt <= '0; prt_ok <= got5 == exp_prt; state <= DEV;
          end
          DEV: if (bcnt == 4'd4) begin
            bcnt <= '0; dev_ok <= got5 == cfg[14:10]; state <= TA;
          end
          TA: begin
            if (bcnt == 4'd0 && rd_go) begin mdio_oe <= 1'b1; mdio_o <= 1'b0; end
            if (bcnt == 4'd1) begin
              bcnt <= '0; state <= DATA;
              if (rd_go) begin mdio_o <= tx_dat[15]; txsh <= {tx_dat[14:0], 1'b0}; end
            end
          end
          DATA: begin
            if (mdio_oe) begin mdio_o <= txsh[15]; txsh <= {txsh[14:0], 1'b0}; end
            if (bcnt == 4'd15) begin
              state <= HUNT; pre_cnt <= '0; mdio_oe <= 1'b0; mdio_o <= 1'b0;
              if (both && op == 2'b00) rx_adr <= {sh[14:0], bit_in};
            end
          end
          default: state <= HUNT;
        endcase
      end
    end
  end
endmodule

module mdio_c45_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdio_oe,
  input logic [2:0]  state,
  input logic [1:0]  op,
  input logic        prt_ok,
  input logic        dev_ok,
  input logic        rd_sts,
  input logic [7:0]  set,
  input logic [7:0]  flags,
  input logic [15:0] rx_adr
);
  // R10
  oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> ((state == 3'd5 || state == 3'd6) && op[1]));
  // R11
  no_drive_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd6 && !(prt_ok && dev_ok)) |-> !mdio_oe);
  // R8
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts && set == 8'h00) |=> flags == 8'h00);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sts |=> (flags & $past(flags)) == $past(flags));
  // R9
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_adr != $past(rx_adr)) |-> flags[1]);
endmodule

bind mdio_c45_slave mdio_c45_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdio_oe(mdio_oe), .state(state), .op(op),
  .prt_ok(prt_ok), .dev_ok(dev_ok), .rd_sts(rd_sts), .set(set),
  .flags(flags), .rx_adr(rx_adr)
);

// File: tb/mdio_c45_slave_test.sv
`timescale 1ns/1ps
module mdio_c45_slave_test;
  localparam int PRE = 16;
  logic clk = 0, rst_n = 0, mdc = 0, mline = 1;
  logic [4:0] pins = 5'b10110;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic mdio_o, mdio_oe;
  wire line = mdio_oe ? mdio_o : mline;
  int total = 0, bad = 0;
  bit allow = 0;
  logic [15:0] m_cfg = 16'h0400, m_tx = 0, m_rx = 0;
  logic [7:0] m_flags = 0;

  always #5 clk = ~clk;

  mdio_c45_slave #(.PRE_MIN(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(line), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .prt_pins(pins), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R11: outside a permitted drive window the enable must stay low, every clock
  always @(negedge clk) if (rst_n && !allow) begin
    total++;
    if (mdio_oe !== 1'b0) begin
      bad++;
      $display("FAIL R11: actual oe=%b expected 0", mdio_oe);
    end
  end

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic bus_wrt(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    if (a == 2'd1) m_tx = d;
    if (a == 2'd2) m_cfg = d & 16'h7FFF;
  endtask

  task automatic tick(input logic b, output logic seen);
    mdc = 0; mline = b;
    repeat (4) @(negedge clk);
    seen = line;
    mdc = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_sts(input string req);
    logic [15:0] d;
    bus_rd(2'd3, d);
    chk(req, d, {8'h00, m_flags});
    m_flags = 0;
  endtask

  task automatic frame(input int npre, input logic [1:0] opc, input logic [4:0] pa,
                       input logic [4:0] da, input logic [15:0] d);
    logic s;
    logic [15:0] got;
    logic [4:0] e;
    bit pm, dm, lng, rd;
    e   = (m_cfg[9:5] & m_cfg[4:0]) | (~m_cfg[9:5] & pins);
    pm  = (pa == e);
    dm  = (da == m_cfg[14:10]);
    lng = (npre >= PRE);
    rd  = opc[1] && pm && dm && lng;
    for (int i = 0; i < npre; i++) tick(1'b1, s);
    tick(1'b0, s); tick(1'b0, s);
    for (int i = 1; i >= 0; i--) tick(opc[i], s);
    for (int i = 4; i >= 0; i--) tick(pa[i], s);
    for (int i = 4; i >= 0; i--) tick(da[i], s);
    if (rd) allow = 1;
    if (opc[1]) begin
      tick(1'b1, s);
      chk("R10 turnaround bit 1 released", {15'd0, s}, 16'd1);
      tick(1'b1, s);
      chk(rd ? "R10 turnaround bit 2 driven low" : "R11 turnaround left high",
          {15'd0, s}, rd ? 16'd0 : 16'd1);
      for (int i = 15; i >= 0; i--) begin tick(1'b1, s); got[i] = s; end
      chk(rd ? "R10 read data MSB first" : "R11 line stays released",
          got, rd ? m_tx : 16'hFFFF);
    end else begin
      tick(1'b1, s); tick(1'b0, s);
      for (int i = 15; i >= 0; i--) tick(d[i], s);
    end
    mline = 1;
    repeat (8) @(negedge clk);
    if (rd) chk("R10 released after data", {15'd0, mdio_oe}, 16'd0);
    allow = 0;
    if (lng) begin
      m_flags |= pm ? 8'h40 : 8'h80;
      m_flags |= dm ? 8'h10 : 8'h20;
      if (pm && dm) begin
        case (opc)
          2'b00: begin m_flags |= 8'h02; m_rx = d; end
          2'b01: m_flags |= 8'h01;
          2'b11: m_flags |= 8'h08;
          default: m_flags |= 8'h04;
        endcase
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    bus_rd(2'd0, d); chk("R1 rx reset", d, 16'h0000);
    bus_rd(2'd1, d); chk("R1 tx reset", d, 16'h0000);
    bus_rd(2'd2, d); chk("R1 cfg reset", d, 16'h0400);
    bus_rd(2'd3, d); chk("R1 status reset", d, 16'h0000);
    chk("R1 oe reset", {15'd0, mdio_oe}, 16'd0);
    // R2 register access
    bus_wrt(2'd1, 16'hBEEF); bus_rd(2'd1, d); chk("R2 tx readback", d, 16'hBEEF);
    bus_wrt(2'd2, 16'hFFFF); bus_rd(2'd2, d); chk("R2 cfg bit15 reads 0", d, 16'h7FFF);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 2'd0; bus_wdata = 16'h7777;
    @(negedge clk); bus_addr = 2'd3;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    bus_rd(2'd0, d); chk("R2 rx not writable", d, 16'h0000);
    bus_rd(2'd3, d); chk("R2 status not writable", d, 16'h0000);
    bus_wrt(2'd2, 16'h0400);
    // R5 R6 R7 R9 address frame
    frame(PRE, 2'b00, pins, 5'd1, 16'h1234);
    check_sts("R7 address frame flags");
    bus_rd(2'd0, d); chk("R9 address captured", d, m_rx);
    bus_rd(2'd3, d); chk("R8 cleared after read", d, 16'h0000);
    // R7 write frame, R9 no capture
    frame(PRE + 3, 2'b01, pins, 5'd1, 16'h5555);
    check_sts("R7 write frame flags");
    bus_rd(2'd0, d); chk("R9 write leaves rx", d, 16'h1234);
    // R3 mixed selection
    bus_wrt(2'd2, {1'b0, 5'd1, 5'b00011, 5'b01001});
    frame(PRE, 2'b00, 5'b10101, 5'd1, 16'hA5A5);
    check_sts("R3 mixed select match");
    frame(PRE, 2'b00, pins, 5'd1, 16'h0F00);
    check_sts("R5 port mismatch flags");
    bus_rd(2'd0, d); chk("R9 mismatch leaves rx", d, 16'hA5A5);
    bus_wrt(2'd2, 16'h0400);
    // R10 read and increment frames
    bus_wrt(2'd1, 16'hBEEF);
    frame(PRE, 2'b11, pins, 5'd1, 16'h0000);
    check_sts("R7 read frame flags");
    bus_wrt(2'd1, 16'h0F0F);
    frame(PRE, 2'b10, pins, 5'd1, 16'h0000);
    check_sts("R7 increment frame flags");
    // R11 device mismatch read, then normal decode
    frame(PRE, 2'b11, pins, 5'd3, 16'h0000);
    check_sts("R6 device mismatch flags");
    frame(PRE, 2'b00, pins, 5'd1, 16'h3C3C);
    check_sts("R11 next frame decoded");
    // R4 preamble boundary
    frame(PRE - 1, 2'b00, pins, 5'd1, 16'h1234);
    check_sts("R4 short preamble ignored");
    bus_rd(2'd0, d); chk("R4 short preamble no capture", d, 16'h3C3C);
    frame(PRE, 2'b00, pins, 5'd1, 16'h4321);
    check_sts("R4 minimum preamble accepted");
    // R8 accumulation
    frame(PRE, 2'b01, pins, 5'd1, 16'h0001);
    frame(PRE, 2'b00, pins, 5'd1, 16'h0002);
    check_sts("R8 flags accumulate");
    // R6 changed device address
    bus_wrt(2'd2, {1'b0, 5'h1F, 10'd0});
    frame(PRE, 2'b00, pins, 5'h1F, 16'h9999);
    check_sts("R6 device address 31 match");
    bus_rd(2'd0, d); chk("R9 capture with dev 31", d, 16'h9999);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule